// File: doc/BRIEF.md
# Compressed-trellis forward metric unit

This unit runs the forward (alpha) recursion of a max-log decoder across one window of an 8-state recursive convolutional code. The code has feedback polynomial 1+D²+D³ and feedforward polynomial 1+D+D³. The window arrives as a stream of segment descriptors, one per clock, after a start strobe that loads the initial state-metric vector.

A stage that carries a parity bit is sent as one full descriptor. A stretch of N ≥ 7 stages without parity is sent in compressed form: seven plain stages, then one reorder descriptor with shift N mod 7. Each plain stage carries the XOR-agglomerated LLR of one residue class of the stretch. Its magnitude is the smallest magnitude in the class and its sign is the product of the signs. The reorder step stands in for the trailing zero-input steps and applies them as a single multiplexer permutation of the metrics. Shorter stretches are sent as raw plain stages.

When the descriptor flagged as last is taken, the unit publishes the end-of-window metric vector and the number of cycles the window took, and raises a one-cycle done pulse. Descriptor kind 3 is reserved and leaves the metrics untouched. The code that produces the agglomerated LLRs sits upstream of this unit.

Top module: `ctrellis_fwd`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0, `cycles_o` is 0 and every field of `end_metrics_o` is 0.
- R2: A plain descriptor (kind 1) performs one max-log add-compare-select stage. The state index is {newest, middle, oldest} register bit. The feedback bit is d ^ middle ^ oldest and the next state is {feedback, newest, middle}. The branch metric is +sys for info bit 0 and −sys for info bit 1, so metrics are held at twice the half-LLR scale.
- R3: A full descriptor (kind 0) performs the same stage and adds +par when the parity bit (feedback ^ newest ^ oldest) is 0 and −par when it is 1.
- R4: A reorder descriptor (kind 2) with shift f moves the metric of each state s to the state that s reaches after f zero-input steps. Seven agglomerated plain stages followed by a reorder with f = N mod 7 give the same end metrics as the N raw stages, up to a common offset.
- R5: After every metric update, each metric is held relative to state 0 and saturated to MW-bit signed. Field s of `end_metrics_o` is bits [s*MW +: MW], and field 0 always reads 0.
- R6: `done_o` pulses in the cycle after the last descriptor is taken. `cycles_o` then equals the number of cycles from the one after start up to and including the last descriptor, with idle gaps counted. This gives 8 for a 64-stage window with no parity and 17 for a 64-stage window with one parity stage at u = 30.
- R7: Descriptors presented while no window is open are ignored. `end_metrics_o` and `cycles_o` hold their values between done pulses.
- R8: A start strobe in the same cycle as the last descriptor of the open window completes that window from its old metrics, and the next window begins from the new initial vector.
- R9: A start strobe in the middle of a window abandons that window without a done pulse, and the restarted window's metrics and cycle count ignore everything that came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Opens a window and loads the initial metrics |
| init_metrics_i | input | 8*MW | Initial metric of state s in bits [s*MW +: MW] |
| seg_valid_i | input | 1 | A descriptor is present this cycle |
| seg_kind_i | input | 2 | 0 full stage, 1 plain stage, 2 reorder, 3 reserved |
| seg_sys_i | input | LLR_W | Signed information-bit LLR, raw or agglomerated |
| seg_par_i | input | LLR_W | Signed parity LLR, used by full stages |
| seg_shift_i | input | 3 | Reorder shift f (number of zero-input steps) |
| seg_last_i | input | 1 | Marks the final descriptor of the window |
| done_o | output | 1 | One-cycle pulse when a window completes |
| end_metrics_o | output | 8*MW | End-of-window metric vector, normalised to state 0 |
| cycles_o | output | CNT_W | Cycle count of the completed window |

## Verification
The finishing of one window and the opening of the next can fall in the same cycle. To provoke this, the bench places the start strobe and a fresh initial vector on the very entry that carries the previous window's last descriptor. Both windows are then judged against a stage-by-stage max-log recursion over the uncompressed bits. The first result must come from the old metrics, and the second window's metrics and cycle count must show no trace of the first.

// File: rtl/ctrellis_pkg.sv
package ctrellis_pkg;

  localparam int NSTATE = 8;
  localparam int SB     = 3;

  typedef enum logic [1:0] {
    SEG_FULL  = 2'd0,
    SEG_PLAIN = 2'd1,
    SEG_PERM  = 2'd2,
    SEG_RSVD  = 2'd3
  } seg_kind_e;

  typedef logic [NSTATE-1:0][SB-1:0] perm_row_t;
  typedef perm_row_t [NSTATE-1:0]    perm_rom_t;

  // state = {newest, middle, oldest}; one step with input 0
  function automatic logic [SB-1:0] zero_step(input logic [SB-1:0] s);
    return {s[1] ^ s[0], s[2], s[1]};
  endfunction

  // predecessor of target t whose oldest bit is x
  function automatic logic [SB-1:0] pred_of(input logic [SB-1:0] t, input logic x);
    return {t[1], t[0], x};
  endfunction

  // information bit on the branch from pred_of(t,x) into t
  function automatic logic info_of(input logic [SB-1:0] t, input logic x);
    return t[2] ^ t[0] ^ x;
  endfunction

  // parity bit on the branch from pred_of(t,x) into t
  function automatic logic parity_of(input logic [SB-1:0] t, input logic x);
    return t[2] ^ t[1] ^ x;
  endfunction

  // rom[f][t] = source state that lands on t after f zero-input steps
  function automatic perm_rom_t build_perm_rom();
    perm_rom_t rom;
    logic [SB-1:0] d;
    rom = '0;
    for (int f = 0; f < NSTATE; f++) begin
      for (int s = 0; s < NSTATE; s++) begin
        d = SB'(s);
        for (int k = 0; k < f; k++) d = zero_step(d);
        rom[SB'(f)][d] = SB'(s);
      end
    end
    return rom;
  endfunction

endpackage

// File: rtl/ctrellis_bm.sv
module ctrellis_bm #(
  parameter int LLR_W = 6
) (
  input  logic [LLR_W-1:0]             sys_i,
  input  logic [LLR_W-1:0]             par_i,
  input  logic                         with_par_i,
  output logic [1:0][1:0][LLR_W+1:0]   bm_o
);

  localparam int BW = LLR_W + 2;

  logic signed [BW-1:0] s_pos, s_neg, p_pos, p_neg;

  assign s_pos = BW'($signed(sys_i));
  assign s_neg = -s_pos;
  assign p_pos = with_par_i ? BW'($signed(par_i)) : '0;
  assign p_neg = -p_pos;

  // bm_o[info][parity]
  for (genvar d = 0; d < 2; d++) begin : g_info
    for (genvar p = 0; p < 2; p++) begin : g_par
      assign bm_o[d][p] = ((d != 0) ? s_neg : s_pos) + ((p != 0) ? p_neg : p_pos);
    end
  end

endmodule

// File: rtl/ctrellis_acs.sv
module ctrellis_acs
  import ctrellis_pkg::*;
#(
  parameter int MW    = 10,
  parameter int LLR_W = 6
) (
  input  logic [NSTATE-1:0][MW-1:0]  met_i,
  input  logic [1:0][1:0][LLR_W+1:0] bm_i,
  output logic [NSTATE-1:0][MW-1:0]  met_o
);

  localparam int BW   = LLR_W + 2;
  localparam int SW   = ((MW > BW) ? MW : BW) + 1;
  localparam int DW   = SW + 1;
  localparam int SMAX = 2 ** (MW - 1) - 1;
  localparam int SMIN = -(2 ** (MW - 1));

  logic signed [SW-1:0] raw [NSTATE];

  for (genvar t = 0; t < NSTATE; t++) begin : g_acs
    localparam logic [SB-1:0] PA = pred_of(SB'(t), 1'b0);
    localparam logic [SB-1:0] PB = pred_of(SB'(t), 1'b1);
    localparam logic          IA = info_of(SB'(t), 1'b0);
    localparam logic          IB = info_of(SB'(t), 1'b1);
    localparam logic          QA = parity_of(SB'(t), 1'b0);
    localparam logic          QB = parity_of(SB'(t), 1'b1);

    logic signed [SW-1:0] cand_a, cand_b;
    logic signed [DW-1:0] diff;
    int                   dv;

    assign cand_a = SW'($signed(met_i[PA])) + SW'($signed(bm_i[IA][QA]));
    assign cand_b = SW'($signed(met_i[PB])) + SW'($signed(bm_i[IB][QB]));
    assign raw[t] = (cand_b > cand_a) ? cand_b : cand_a;

    // normalise to state 0 and saturate
    assign diff = DW'(raw[t]) - DW'(raw[0]);
    always_comb begin
      dv = int'(diff);
      if (dv > SMAX)      met_o[t] = MW'(SMAX);
      else if (dv < SMIN) met_o[t] = MW'(SMIN);
      else                met_o[t] = MW'(dv);
    end
  end

endmodule

// File: rtl/ctrellis_perm.sv
module ctrellis_perm
  import ctrellis_pkg::*;
#(
  parameter int MW = 10
) (
  input  logic [NSTATE-1:0][MW-1:0] met_i,
  input  logic [SB-1:0]             shift_i,
  output logic [NSTATE-1:0][MW-1:0] met_o
);

  localparam perm_rom_t ROM = build_perm_rom();

  for (genvar t = 0; t < NSTATE; t++) begin : g_mux
    assign met_o[t] = met_i[ROM[shift_i][t]];
  end

endmodule

// File: rtl/ctrellis_fwd.sv
module ctrellis_fwd
  import ctrellis_pkg::*;
#(
  parameter int MW    = 10,
  parameter int LLR_W = 6,
  parameter int CNT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [NSTATE*MW-1:0]   init_metrics_i,
  input  logic                   seg_valid_i,
  input  logic [1:0]             seg_kind_i,
  input  logic [LLR_W-1:0]       seg_sys_i,
  input  logic [LLR_W-1:0]       seg_par_i,
  input  logic [SB-1:0]          seg_shift_i,
  input  logic                   seg_last_i,
  output logic                   done_o,
  output logic [NSTATE*MW-1:0]   end_metrics_o,
  output logic [CNT_W-1:0]       cycles_o
);

  typedef logic [NSTATE-1:0][MW-1:0] mvec_t;

  mvec_t                    work_q, work_d, res_q, res_d;
  mvec_t                    acs_vec, perm_vec, upd_vec;
  logic                     busy_q, busy_d, done_q, done_d;
  logic [CNT_W-1:0]         cnt_q, cnt_d, cyc_q, cyc_d, cnt_inc;
  logic [1:0][1:0][LLR_W+1:0] bm;
  seg_kind_e                kind;
  logic                     accept, finish, is_full;
  logic                     work_en, res_en, cnt_en;

  assign kind    = seg_kind_e'(seg_kind_i);
  assign accept  = busy_q & seg_valid_i;
  assign finish  = accept & seg_last_i;
  assign is_full = (kind == SEG_FULL);

  ctrellis_bm #(.LLR_W(LLR_W)) bm_i (
    .sys_i      (seg_sys_i),
    .par_i      (seg_par_i),
    .with_par_i (is_full),
    .bm_o       (bm)
  );

  ctrellis_acs #(.MW(MW), .LLR_W(LLR_W)) acs_i (
    .met_i (work_q),
    .bm_i  (bm),
    .met_o (acs_vec)
  );

  ctrellis_perm #(.MW(MW)) perm_i (
    .met_i   (work_q),
    .shift_i (seg_shift_i),
    .met_o   (perm_vec)
  );

  always_comb begin
    unique case (kind)
      SEG_FULL, SEG_PLAIN: upd_vec = acs_vec;
      SEG_PERM:            upd_vec = perm_vec;
      default:             upd_vec = work_q;
    endcase
  end

  assign cnt_inc = (cnt_q == {CNT_W{1'b1}}) ? cnt_q : cnt_q + 1'b1;

  // next-state logic
  always_comb begin
    work_d = work_q;
    if (start_i)     work_d = mvec_t'(init_metrics_i);
    else if (accept) work_d = upd_vec;

    busy_d = busy_q;
    if (start_i)     busy_d = 1'b1;
    else if (finish) busy_d = 1'b0;

    cnt_d = cnt_q;
    if (start_i)     cnt_d = '0;
    else if (busy_q) cnt_d = cnt_inc;

    done_d = finish;
    res_d  = finish ? upd_vec : res_q;
    cyc_d  = finish ? cnt_inc : cyc_q;
  end

  assign work_en = start_i | accept;
  assign res_en  = finish;
  assign cnt_en  = start_i | busy_q;

  // control and result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      cyc_q  <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (res_en) begin
        cyc_q <= cyc_d;
        res_q <= res_d;
      end
    end
  end

  // working metrics: loaded at start, no reset needed
  always_ff @(posedge clk) begin
    if (work_en) work_q <= work_d;
  end

  assign done_o        = done_q;
  assign end_metrics_o = res_q;
  assign cycles_o      = cyc_q;

endmodule

// File: rtl/ctrellis_fwd_chk.sv
module ctrellis_fwd_chk
  import ctrellis_pkg::*;
#(
  parameter int MW    = 10,
  parameter int CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start_i,
  input logic                 seg_valid_i,
  input logic                 seg_last_i,
  input logic                 busy_i,
  input logic                 done_i,
  input logic [NSTATE*MW-1:0] metrics_i,
  input logic [CNT_W-1:0]     cycles_i
);

  logic fin;
  assign fin = busy_i & seg_valid_i & seg_last_i;

  // R5
  state0_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (metrics_i[MW-1:0] == '0));

  // R6
  cycles_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> (cycles_i != '0));

  // R6
  done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> done_i);

  // R7
  idle_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |=> !done_i);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> ($stable(metrics_i) && $stable(cycles_i)));

  // R8
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_i);

  // R9
  abort_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_i && !(seg_valid_i && seg_last_i)) |=> !done_i);

endmodule

bind ctrellis_fwd ctrellis_fwd_chk #(.MW(MW), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .seg_valid_i (seg_valid_i),
  .seg_last_i  (seg_last_i),
  .busy_i      (busy_q),
  .done_i      (done_o),
  .metrics_i   (end_metrics_o),
  .cycles_i    (cycles_o)
);

// File: tb/ctrellis_fwd_tb_top.sv
module ctrellis_fwd_tb_top;

  localparam int MW = 10, LLR_W = 6, CNT_W = 8, NS = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                 rst_n, start_i, seg_valid_i, seg_last_i, done_o;
  logic [NS*MW-1:0]     init_metrics_i, end_metrics_o;
  logic [1:0]           seg_kind_i;
  logic [LLR_W-1:0]     seg_sys_i, seg_par_i;
  logic [2:0]           seg_shift_i;
  logic [CNT_W-1:0]     cycles_o;

  ctrellis_fwd #(.MW(MW), .LLR_W(LLR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .init_metrics_i(init_metrics_i),
    .seg_valid_i(seg_valid_i), .seg_kind_i(seg_kind_i), .seg_sys_i(seg_sys_i),
    .seg_par_i(seg_par_i), .seg_shift_i(seg_shift_i), .seg_last_i(seg_last_i),
    .done_o(done_o), .end_metrics_o(end_metrics_o), .cycles_o(cycles_o)
  );

  typedef struct {
    bit start; int init[NS]; bit v; int kind; int sys; int par; int shift; bit last;
  } stim_t;
  typedef struct { int m[NS]; int cyc; string tag; } exp_t;

  stim_t stim[$];
  exp_t  expq[$];
  exp_t  held;
  int    nchk = 0, nfail = 0;
  int    ref_m[NS];
  int    win_cyc;

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom_range(hi - lo));
  endfunction

  // behavioural encoder-driven max-log stage over the raw trellis
  task automatic ref_stage(int ls, int lp, bit has_par);
    int nm[NS];
    for (int t = 0; t < NS; t++) nm[t] = -1000000;
    for (int s = 0; s < NS; s++) begin
      for (int d = 0; d < 2; d++) begin
        int r0 = (s >> 2) & 1, r1 = (s >> 1) & 1, r2 = s & 1;
        int fb = d ^ r1 ^ r2;
        int pb = fb ^ r0 ^ r2;
        int ns = fb * 4 + r0 * 2 + r1;
        int bm = ((d != 0) ? -ls : ls) + (has_par ? ((pb != 0) ? -lp : lp) : 0);
        if (ref_m[s] + bm > nm[ns]) nm[ns] = ref_m[s] + bm;
      end
    end
    for (int t = 0; t < NS; t++) ref_m[t] = nm[t];
  endtask

  task automatic begin_window(bit merge);
    stim_t e;
    e = '{default: 0};
    for (int s = 0; s < NS; s++) begin
      e.init[s] = rnd(-120, 120);
      ref_m[s]  = e.init[s];
    end
    if (merge) begin
      stim[stim.size()-1].start = 1'b1;
      stim[stim.size()-1].init  = e.init;
    end else begin
      e.start = 1'b1;
      stim.push_back(e);
    end
    win_cyc = 0;
  endtask

  task automatic desc(int kind, int sys, int par, int shift);
    stim_t e;
    e = '{default: 0};
    e.v = 1'b1; e.kind = kind; e.sys = sys; e.par = par; e.shift = shift;
    stim.push_back(e);
    win_cyc++;
  endtask

  task automatic gap(int k);
    stim_t e;
    e = '{default: 0};
    for (int i = 0; i < k; i++) begin stim.push_back(e); win_cyc++; end
  endtask

  task automatic add_par();
    int ls = rnd(-31, 31), lp = rnd(-31, 31);
    ref_stage(ls, lp, 1'b1);
    desc(0, ls, lp, 0);
  endtask

  task automatic add_run(int n);
    int l[$];
    for (int i = 0; i < n; i++) begin
      l.push_back(rnd(-31, 31));
      ref_stage(l[i], 0, 1'b0);
    end
    if (n < 7) begin
      for (int i = 0; i < n; i++) desc(1, l[i], 0, 0);
    end else begin
      for (int g = 0; g < 7; g++) begin
        int mag = 1000; bit neg = 1'b0;
        for (int i = g; i < n; i += 7) begin
          int a = (l[i] < 0) ? -l[i] : l[i];
          if (a < mag) mag = a;
          if (l[i] < 0) neg = ~neg;
        end
        desc(1, neg ? -mag : mag, 0, 0);
      end
      desc(2, 0, 0, n % 7);
    end
  endtask

  task automatic end_window(string tag);
    exp_t x;
    stim[stim.size()-1].last = 1'b1;
    for (int s = 0; s < NS; s++) x.m[s] = ref_m[s] - ref_m[0];
    x.cyc = win_cyc;
    x.tag = tag;
    expq.push_back(x);
  endtask

  task automatic drive(stim_t e);
    start_i     = e.start;
    for (int s = 0; s < NS; s++) init_metrics_i[s*MW +: MW] = MW'(e.init[s]);
    seg_valid_i = e.v;
    seg_kind_i  = 2'(e.kind);
    seg_sys_i   = LLR_W'(e.sys);
    seg_par_i   = LLR_W'(e.par);
    seg_shift_i = 3'(e.shift);
    seg_last_i  = e.last;
  endtask

  function automatic int field(int s);
    return int'($signed(end_metrics_o[s*MW +: MW]));
  endfunction

  task automatic check_outputs();
    exp_t x;
    string tag;
    bit bad;
    if (done_o) begin
      nchk++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R7 unexpected done: actual done=1 expected done=0");
        return;
      end
      x = expq.pop_front();
      held = x;
      bad = 1'b0;
      for (int s = 0; s < NS && !bad; s++) begin
        if (field(s) != x.m[s]) begin
          tag = (s == 0) ? "R5" : x.tag;
          nfail++; bad = 1'b1;
          $display("FAIL %s metric of state %0d: actual %0d expected %0d", tag, s, field(s), x.m[s]);
        end
      end
      nchk++;
      if (int'(cycles_o) != x.cyc) begin
        nfail++;
        $display("FAIL R6 cycle count (%s window): actual %0d expected %0d", x.tag, cycles_o, x.cyc);
      end
    end else begin
      nchk++;
      bad = (int'(cycles_o) != held.cyc);
      for (int s = 0; s < NS; s++) if (field(s) != held.m[s]) bad = 1'b1;
      if (bad) begin
        nfail++;
        $display("FAIL R7 outputs changed without done: actual cycles %0d state1 %0d expected cycles %0d state1 %0d",
                 cycles_o, field(1), held.cyc, held.m[1]);
      end
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R6 watchdog expired: actual hung expected completion");
    summary();
    $finish;
  end

  initial begin
    stim_t idle;
    idle = '{default: 0};
    held.cyc = 0;
    for (int s = 0; s < NS; s++) held.m[s] = 0;
    held.tag = "R1";
    rst_n = 1'b0;
    drive(idle);

    // R1: reset state
    repeat (3) @(negedge clk);
    nchk++;
    if (done_o !== 1'b0 || cycles_o !== '0 || end_metrics_o !== '0) begin
      nfail++;
      $display("FAIL R1 reset state: actual done=%0b cycles=%0d metrics=%h expected 0/0/0",
               done_o, cycles_o, end_metrics_o);
    end
    rst_n = 1'b1;

    // R4, R6: 64 parity-free stages -> 8 cycles
    begin_window(0); add_run(64); end_window("R4");
    // R3, R6: one parity stage at u=30 -> 17 cycles
    begin_window(0); add_run(29); add_par(); add_run(34); end_window("R3");
    // R2: short runs sent raw
    begin_window(0); add_run(3); add_par(); add_run(4); add_par(); add_par(); end_window("R2");
    // R3: parity stages only
    begin_window(0); for (int i = 0; i < 6; i++) add_par(); end_window("R3");
    // R4: shift 0, shift 3, minimum run of 7
    begin_window(0); add_run(14); add_run(7); add_par(); add_run(10); end_window("R4");
    // R7: descriptors while no window is open
    gap(1); desc(1, 20, 0, 0); desc(2, 0, 0, 3); desc(0, -9, 11, 0);
    stim[stim.size()-1].last = 1'b1; gap(2);
    // R6: idle gaps inside a window are counted
    begin_window(0); add_run(9); gap(3); add_par(); end_window("R6");
    // R8: start on the same cycle as the last descriptor
    begin_window(0); add_run(12); end_window("R8");
    begin_window(1); add_par(); add_run(8); end_window("R8");
    gap(2);
    // R9: restart in mid-window
    begin_window(0); add_run(2); add_par();
    begin_window(0); add_run(20); end_window("R9");
    // mixed windows
    for (int w = 0; w < 20; w++) begin
      begin_window(0);
      for (int k = 0; k < 3; k++) begin
        if (rnd(0, 1) == 1) add_par();
        add_run(rnd(1, 40));
      end
      add_par();
      end_window("R4");
      if (rnd(0, 2) == 0) gap(rnd(1, 3));
    end

    foreach (stim[i]) begin
      @(negedge clk);
      check_outputs();
      drive(stim[i]);
    end
    repeat (6) begin
      @(negedge clk);
      check_outputs();
      drive(idle);
    end
    nchk++;
    if (expq.size() != 0) begin
      nfail++;
      $display("FAIL R6 missing done pulses: actual %0d outstanding expected 0", expq.size());
    end
    summary();
    $finish;
  end

endmodule